// File: doc/BRIEF.md
# ETU-Timed Character Serializer and Deserializer

This block turns bytes into a baseband bit stream and back, with all timing counted in elementary time units (ETUs). One ETU is a fixed number of carrier-rate clock enables (`tick_i`), 128 by default. The block advances only on cycles where `tick_i` is high. Each character on the line is a low start bit, eight data bits with the least significant bit first, and a high stop bit.

The receive half watches an idle-high line for a falling edge. It restarts its bit timing on every start bit and samples each bit once, in the middle of its ETU. Each byte it assembles goes to the command layer with a one-cycle strobe. A bad stop bit gives an error strobe and the byte is dropped. When the line stays idle for longer than the allowed inter-character gap, the frame is closed with a frame-done strobe.

The transmit half starts a response when the command layer offers its first byte. It stays silent for a fixed delay, then enables the subcarrier with the line held high as a preamble, then sends characters separated by a fixed guard time. The command layer supplies bytes in the order they go on the line, so a multi-byte value must be offered least significant byte first. If no byte is waiting when a guard time ends, the response is finished.

Top module: `etu_char_link`

## Requirements
- R1: All timing advances only on cycles with `tick_i` high, and one ETU is `ETU_TICKS` ticks (128 by default). While `tick_i` is low, the transmit outputs hold and no receive strobe is raised.
- R2: A received character (low start bit, 8 data bits LSB first, high stop bit) sets `rx_data_o` to the byte and pulses `rx_valid_o` for one cycle just after the stop bit is sampled.
- R3: Every bit is sampled once, 64 ticks (half an ETU) after its boundary. A low pulse that has ended before the middle of the start bit is treated as a false start and gives no strobe.
- R4: The receiver restarts its bit timing at the falling edge of every start bit, so characters with arbitrary idle gaps and a bit period that is off by up to about 5 % are still decoded.
- R5: A stop bit sampled low pulses `rx_err_o` for one cycle and gives no `rx_valid_o` for that character. `rx_valid_o` and `rx_err_o` are never high together.
- R6: Once a frame has started, an idle line lasting more than 6 ETUs after the end of the last stop bit pulses `rx_done_o` once. Gaps of 6 ETUs or less keep the frame open.
- R7: When the first byte of a response is accepted, `tx_line_o` stays high and `tx_en_o` stays low for 8 ETUs.
- R8: After the delay, `tx_en_o` rises and the line stays high for a preamble of exactly 10 ETUs. Then the start bit of the first character begins.
- R9: Each transmitted character is a low start bit, the 8 data bits LSB first, and a high stop bit, each lasting one ETU.
- R10: Consecutive transmitted characters are separated by exactly 2 ETUs of high line, so their start bits are 12 ETUs apart.
- R11: `tx_ready_o` is high while the transmitter is idle, and for the single cycle that ends each guard time. A byte is taken when `tx_valid_i` and `tx_ready_o` are both high. If no byte is offered when a guard time ends, `tx_done_o` pulses and `tx_en_o` falls.
- R12: After reset, `tx_line_o` is high, `tx_en_o` is low, `tx_ready_o` is high, and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Carrier-rate clock enable |
| rx_line_i | input | 1 | Received baseband line, idle high |
| rx_data_o | output | DATA_W | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a good byte |
| rx_err_o | output | 1 | One-cycle strobe for a bad stop bit |
| rx_done_o | output | 1 | One-cycle strobe at end of a received frame |
| tx_data_i | input | DATA_W | Byte to transmit |
| tx_valid_i | input | 1 | Transmit byte offered |
| tx_ready_o | output | 1 | Transmitter takes the offered byte this cycle |
| tx_line_o | output | 1 | Transmitted baseband line, idle high |
| tx_en_o | output | 1 | Subcarrier enable (preamble and characters) |
| tx_done_o | output | 1 | One-cycle strobe at end of a response |

## Verification
The assertions assume that `rx_line_i` and `tx_valid_i` change only at the falling clock edge. They also assume that `tx_valid_i`, once raised, stays high until the byte is taken. The bench drives every input from negative-edge tasks and keeps each byte offered until it sees `tx_ready_o`. The receive checks assume that a frame's idle gaps stay inside the timeout, so the stimulus table uses gaps of at most 700 cycles. The table's bit periods stay between 122 and 134 cycles, which keeps the drift within half an ETU across one character.

// File: rtl/etu_pkg.sv
package etu_pkg;
  typedef enum logic {
    RX_WAIT,
    RX_BITS
  } rx_state_e;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_DELAY,
    TX_PRE,
    TX_CHAR,
    TX_GUARD
  } tx_state_e;
endpackage

// File: rtl/etu_rx.sv
module etu_rx
  import etu_pkg::*;
#(
  parameter int ETU_TICKS   = 128,
  parameter int DATA_W      = 8,
  parameter int MAX_GAP_ETU = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              line_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              err_o,
  output logic              done_o
);
  localparam int NBITS     = DATA_W + 2;
  localparam int HALF      = ETU_TICKS / 2;
  localparam int PW        = $clog2(ETU_TICKS);
  localparam int IW        = $clog2(NBITS);
  localparam int GAP_LIMIT = HALF + MAX_GAP_ETU * ETU_TICKS;
  localparam int GW        = $clog2(GAP_LIMIT + 1);

  localparam logic [PW-1:0] PH_MID  = PW'(HALF);
  localparam logic [PW-1:0] PH_LAST = PW'(ETU_TICKS - 1);
  localparam logic [IW-1:0] IDX_STOP = IW'(NBITS - 1);
  localparam logic [GW-1:0] GAP_END = GW'(GAP_LIMIT);

  rx_state_e         state_q;
  logic [PW-1:0]     ph_q;
  logic [IW-1:0]     idx_q;
  logic [DATA_W-1:0] shreg_q;
  logic [GW-1:0]     gap_q;
  logic              line_q;
  logic              in_frame_q;
  logic              fall;

  assign fall = line_q & ~line_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= RX_WAIT;
      ph_q       <= '0;
      idx_q      <= '0;
      shreg_q    <= '0;
      gap_q      <= '0;
      line_q     <= 1'b1;
      in_frame_q <= 1'b0;
      data_o     <= '0;
      valid_o    <= 1'b0;
      err_o      <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      done_o  <= 1'b0;
      if (tick_i) begin
        line_q <= line_i;
        unique case (state_q)
          RX_WAIT: begin
            if (fall) begin
              // realign on every start edge
              state_q <= RX_BITS;
              ph_q    <= PW'(1);
              idx_q   <= '0;
              gap_q   <= '0;
            end else if (in_frame_q) begin
              if (gap_q == GAP_END) begin
                done_o     <= 1'b1;
                in_frame_q <= 1'b0;
                gap_q      <= '0;
              end else begin
                gap_q <= gap_q + 1'b1;
              end
            end
          end
          RX_BITS: begin
            ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
            if (ph_q == PH_MID) begin
              if (idx_q == '0) begin
                if (line_i) state_q <= RX_WAIT;  // false start
                else        idx_q   <= IW'(1);
              end else if (idx_q == IDX_STOP) begin
                state_q    <= RX_WAIT;
                in_frame_q <= 1'b1;
                gap_q      <= '0;
                if (line_i) begin
                  data_o  <= shreg_q;
                  valid_o <= 1'b1;
                end else begin
                  err_o <= 1'b1;
                end
              end else begin
                shreg_q <= {line_i, shreg_q[DATA_W-1:1]};
                idx_q   <= idx_q + 1'b1;
              end
            end
          end
          default: state_q <= RX_WAIT;
        endcase
      end
    end
  end

  p_strobe_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && err_o));

  p_valid_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_done_alone_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o && !err_o);

  p_no_tick_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !valid_o && !err_o && !done_o);
endmodule

// File: rtl/etu_tx.sv
module etu_tx
  import etu_pkg::*;
#(
  parameter int ETU_TICKS = 128,
  parameter int DATA_W    = 8,
  parameter int DELAY_ETU = 8,
  parameter int PRE_ETU   = 10,
  parameter int GUARD_ETU = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              line_o,
  output logic              en_o,
  output logic              done_o
);
  localparam int NBITS   = DATA_W + 2;
  localparam int DELAY_T = DELAY_ETU * ETU_TICKS;
  localparam int PRE_T   = PRE_ETU * ETU_TICKS;
  localparam int GUARD_T = GUARD_ETU * ETU_TICKS;
  localparam int MAX_A   = (DELAY_T > PRE_T) ? DELAY_T : PRE_T;
  localparam int MAX_B   = (GUARD_T > ETU_TICKS) ? GUARD_T : ETU_TICKS;
  localparam int MAXT    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW      = $clog2(MAXT + 1);
  localparam int IW      = $clog2(NBITS);

  localparam logic [CW-1:0] DELAY_END = CW'(DELAY_T - 1);
  localparam logic [CW-1:0] PRE_END   = CW'(PRE_T - 1);
  localparam logic [CW-1:0] GUARD_END = CW'(GUARD_T - 1);
  localparam logic [CW-1:0] BIT_END   = CW'(ETU_TICKS - 1);
  localparam logic [IW-1:0] IDX_STOP  = IW'(NBITS - 1);

  tx_state_e        state_q;
  logic [CW-1:0]    cnt_q;
  logic [IW-1:0]    idx_q;
  logic [NBITS-1:0] shreg_q;
  logic             guard_end;

  assign guard_end = (state_q == TX_GUARD) && tick_i && (cnt_q == GUARD_END);
  assign ready_o   = (state_q == TX_IDLE) || guard_end;
  assign line_o    = (state_q == TX_CHAR) ? shreg_q[0] : 1'b1;
  assign en_o      = (state_q == TX_PRE) || (state_q == TX_CHAR) || (state_q == TX_GUARD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shreg_q <= '1;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        TX_IDLE: begin
          if (valid_i) begin
            shreg_q <= {1'b1, data_i, 1'b0};
            cnt_q   <= '0;
            state_q <= TX_DELAY;
          end
        end
        TX_DELAY: begin
          if (tick_i) begin
            if (cnt_q == DELAY_END) begin
              cnt_q   <= '0;
              state_q <= TX_PRE;
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
        TX_PRE: begin
          if (tick_i) begin
            if (cnt_q == PRE_END) begin
              cnt_q   <= '0;
              idx_q   <= '0;
              state_q <= TX_CHAR;
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
        TX_CHAR: begin
          if (tick_i) begin
            if (cnt_q == BIT_END) begin
              cnt_q   <= '0;
              shreg_q <= {1'b1, shreg_q[NBITS-1:1]};
              if (idx_q == IDX_STOP) state_q <= TX_GUARD;
              else                   idx_q   <= idx_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
        TX_GUARD: begin
          if (tick_i) begin
            if (cnt_q == GUARD_END) begin
              cnt_q <= '0;
              if (valid_i) begin
                shreg_q <= {1'b1, data_i, 1'b0};
                idx_q   <= '0;
                state_q <= TX_CHAR;
              end else begin
                done_o  <= 1'b1;
                state_q <= TX_IDLE;
              end
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  p_accept_silent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o && !en_o) |=> !en_o && !ready_o && line_o);

  p_done_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !en_o && ready_o);

  p_stall_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && en_o) |=> $stable(line_o) && $stable(en_o));

  p_preamble_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_o) |-> line_o && !ready_o);
endmodule

// File: rtl/etu_char_link.sv
module etu_char_link #(
  parameter int ETU_TICKS   = 128,
  parameter int DATA_W      = 8,
  parameter int MAX_GAP_ETU = 6,
  parameter int DELAY_ETU   = 8,
  parameter int PRE_ETU     = 10,
  parameter int GUARD_ETU   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_line_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              rx_err_o,
  output logic              rx_done_o,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              tx_line_o,
  output logic              tx_en_o,
  output logic              tx_done_o
);
  etu_rx #(
    .ETU_TICKS  (ETU_TICKS),
    .DATA_W     (DATA_W),
    .MAX_GAP_ETU(MAX_GAP_ETU)
  ) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .line_i (rx_line_i),
    .data_o (rx_data_o),
    .valid_o(rx_valid_o),
    .err_o  (rx_err_o),
    .done_o (rx_done_o)
  );

  etu_tx #(
    .ETU_TICKS(ETU_TICKS),
    .DATA_W   (DATA_W),
    .DELAY_ETU(DELAY_ETU),
    .PRE_ETU  (PRE_ETU),
    .GUARD_ETU(GUARD_ETU)
  ) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .data_i (tx_data_i),
    .valid_i(tx_valid_i),
    .ready_o(tx_ready_o),
    .line_o (tx_line_o),
    .en_o   (tx_en_o),
    .done_o (tx_done_o)
  );
endmodule

// File: tb/etu_char_link_test.sv
module etu_char_link_test;
  localparam int CLK_PERIOD = 10;
  localparam int ETU = 128;
  localparam int NVEC = 6;
  // {byte[31:24], idle gap before char in cycles [23:12], bit period in cycles [11:0]}
  localparam logic [31:0] RX_VEC [NVEC] = '{
    {8'hA5, 12'd0,   12'd128},
    {8'h00, 12'd200, 12'd128},
    {8'hFF, 12'd333, 12'd122},
    {8'h3C, 12'd640, 12'd134},
    {8'h81, 12'd37,  12'd128},
    {8'h5A, 12'd700, 12'd128}
  };
  localparam logic [7:0] TX_BYTES [3] = '{8'hA5, 8'h3C, 8'h01};

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b1;
  logic       half_mode = 1'b0;
  logic       rx_line_i = 1'b1;
  logic [7:0] rx_data_o;
  logic       rx_valid_o, rx_err_o, rx_done_o;
  logic [7:0] tx_data_i = '0;
  logic       tx_valid_i = 1'b0;
  logic       tx_ready_o, tx_line_o, tx_en_o, tx_done_o;

  int checks = 0;
  int errors = 0;
  int rx_cnt = 0, err_cnt = 0, done_cnt = 0, txd_cnt = 0;
  logic [7:0] rx_last = '0;
  longint t_acc, t_en;
  longint t_st [3];

  etu_char_link uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .rx_line_i(rx_line_i),
    .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .rx_err_o(rx_err_o),
    .rx_done_o(rx_done_o), .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i),
    .tx_ready_o(tx_ready_o), .tx_line_o(tx_line_o), .tx_en_o(tx_en_o),
    .tx_done_o(tx_done_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) tick_i <= half_mode ? ~tick_i : 1'b1;

  always @(negedge clk) begin
    if (rx_valid_o) begin rx_cnt++; rx_last = rx_data_o; end
    if (rx_err_o)  err_cnt++;
    if (rx_done_o) done_cnt++;
    if (tx_done_o) txd_cnt++;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_char(input logic [7:0] b, input logic stop, input int etu);
    rx_line_i = 1'b0;
    repeat (etu) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_line_i = b[i];
      repeat (etu) @(negedge clk);
    end
    rx_line_i = stop;
    repeat (etu) @(negedge clk);
    rx_line_i = 1'b1;
  endtask

  task automatic push(input logic [7:0] b, output longint t);
    tx_data_i  = b;
    tx_valid_i = 1'b1;
    while (!tx_ready_o) @(negedge clk);
    t = $time;
    @(negedge clk);
    tx_valid_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int n0, e0, d0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(tx_line_o === 1'b1, "R12 tx_line", tx_line_o, 1);
    check(tx_en_o === 1'b0, "R12 tx_en", tx_en_o, 0);
    check(tx_ready_o === 1'b1, "R12 tx_ready", tx_ready_o, 1);
    check(!rx_valid_o && !rx_err_o && !rx_done_o && !tx_done_o, "R12 strobes",
          {rx_valid_o, rx_err_o, rx_done_o, tx_done_o}, 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);

    // R2/R4: table-driven frame with varied gaps and bit periods
    for (int v = 0; v < NVEC; v++) begin
      n0 = rx_cnt;
      repeat (int'(RX_VEC[v][23:12])) @(negedge clk);
      send_char(RX_VEC[v][31:24], 1'b1, int'(RX_VEC[v][11:0]));
      check(rx_cnt == n0 + 1, "R2 byte strobe count", rx_cnt, n0 + 1);
      check(rx_last == RX_VEC[v][31:24], "R4 realigned byte", rx_last, RX_VEC[v][31:24]);
    end
    check(done_cnt == 0, "R6 frame open within gap", done_cnt, 0);
    repeat (900) @(negedge clk);
    check(done_cnt == 1, "R6 frame done after long gap", done_cnt, 1);

    // R5 framing error
    n0 = rx_cnt; e0 = err_cnt;
    send_char(8'h55, 1'b0, ETU);
    check(err_cnt == e0 + 1, "R5 error strobe", err_cnt, e0 + 1);
    check(rx_cnt == n0, "R5 byte dropped", rx_cnt, n0);
    repeat (1000) @(negedge clk);
    check(done_cnt == 2, "R6 done after errored frame", done_cnt, 2);

    // R3 short glitch is a false start
    n0 = rx_cnt; e0 = err_cnt; d0 = done_cnt;
    rx_line_i = 1'b0;
    repeat (20) @(negedge clk);
    rx_line_i = 1'b1;
    repeat (1500) @(negedge clk);
    check(rx_cnt == n0, "R3 glitch no byte", rx_cnt, n0);
    check(err_cnt == e0, "R3 glitch no error", err_cnt, e0);
    check(done_cnt == d0, "R3 glitch no frame", done_cnt, d0);

    // R1 half-rate tick: ETU spans 256 cycles
    half_mode = 1'b1;
    repeat (4) @(negedge clk);
    n0 = rx_cnt;
    send_char(8'hC3, 1'b1, 2 * ETU);
    check(rx_cnt == n0 + 1, "R1 byte at half tick rate", rx_cnt, n0 + 1);
    check(rx_last == 8'hC3, "R1 data at half tick rate", rx_last, 8'hC3);
    repeat (2000) @(negedge clk);
    half_mode = 1'b0;
    repeat (4) @(negedge clk);

    // transmit response
    fork
      begin : drv
        longint t;
        push(TX_BYTES[0], t_acc);
        push(TX_BYTES[1], t);
        push(TX_BYTES[2], t);
      end
      begin : mon
        logic [7:0] got;
        logic st, sp;
        while (!tx_en_o) @(negedge clk);
        t_en = $time;
        for (int c = 0; c < 3; c++) begin
          while (tx_line_o) @(negedge clk);
          t_st[c] = $time;
          repeat (ETU/2) @(negedge clk);
          st = tx_line_o;
          for (int i = 0; i < 8; i++) begin
            repeat (ETU) @(negedge clk);
            got[i] = tx_line_o;
          end
          repeat (ETU) @(negedge clk);
          sp = tx_line_o;
          check(st == 1'b0, "R9 start bit", st, 0);
          check(got == TX_BYTES[c], "R9 data LSB first", got, TX_BYTES[c]);
          check(sp == 1'b1, "R9 stop bit", sp, 1);
        end
      end
    join
    // accept edge + 8 ETUs, seen at the following negedge
    check((t_en - t_acc) / CLK_PERIOD == 8 * ETU + 1, "R7 silent delay",
          (t_en - t_acc) / CLK_PERIOD, 8 * ETU + 1);
    check((t_st[0] - t_en) / CLK_PERIOD == 10 * ETU, "R8 preamble length",
          (t_st[0] - t_en) / CLK_PERIOD, 10 * ETU);
    for (int c = 1; c < 3; c++)
      check((t_st[c] - t_st[c-1]) / CLK_PERIOD == 12 * ETU, "R10 guard spacing",
            (t_st[c] - t_st[c-1]) / CLK_PERIOD, 12 * ETU);
    check(txd_cnt == 0, "R11 no done before last guard", txd_cnt, 0);
    repeat (400) @(negedge clk);
    check(txd_cnt == 1, "R11 done on empty guard end", txd_cnt, 1);
    check(tx_en_o == 1'b0 && tx_ready_o == 1'b1, "R11 idle after response",
          {tx_en_o, tx_ready_o}, 1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule